// File: doc/BRIEF.md
# Two-Stage Fractional Baud Tick Generator

This block derives a serial bit-rate strobe from the system clock. It works in two stages. An integer prescaler divides the clock by `scale + 1`. Each prescaler pulse then adds a 16-bit `step` into a 17-bit phase accumulator. Whenever that addition wraps past 2^17, the block emits a single-cycle `tick`. The long-run tick rate is therefore `f_clk * step / ((scale + 1) * 2^17)`. Most rates can be reached this way with a small error, which a plain divide-by-N counter cannot do.

Software chooses `scale` and `step` and holds them steady. The block watches both values and the enable. If `en` is low, or if either value differs from what it held on the previous clock edge, both stages are cleared. The next period then starts from a zero phase.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst` is high, `tick` is 0 after every clock edge, and both stages restart from zero when `rst` is released.
- R2: `tick` is high for exactly one clock at a time, and it is never high in two consecutive cycles.
- R3: The prescaler counts 0, 1, ..., `scale` and pulses on the edge where it wraps back to 0. With `scale = 0` it pulses on every enabled edge.
- R4: Count enabled edges from 1 after the last clear. On edge k with k a multiple of `scale+1`, let p = k/(`scale`+1). The accumulator adds `step` modulo 2^17. `tick` is 1 after that edge exactly when floor(p*`step`/2^17) exceeds floor((p-1)*`step`/2^17). After every other edge `tick` is 0.
- R5: With `step = 0`, `tick` stays 0.
- R6: Over a window of (`scale`+1) * 2^17 enabled edges that starts at a clear, with the inputs held constant, exactly `step` ticks occur.
- R7: On every edge where `en` is low, `tick` is 0 and both stages clear. The first edge with `en` high counts as k = 1.
- R8: On the edge where `scale` or `step` first differs from its value at the previous edge, `tick` is 0 and both stages clear. The next edge counts as k = 1.
- R9: The maximum `scale` of 0xFFF divides by 4096. With `step = 0xFFFF`, the first tick appears after edge 3*4096.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears both stages |
| scale | input | 12 | Prescaler divide value minus one |
| step | input | 16 | Phase increment added per prescaler pulse |
| tick | output | 1 | Registered one-cycle rate strobe |

## Verification
On every cycle, the embedded assertions check four things. The prescaler count stays within `scale`. A tick always follows a prescaler pulse. No tick is ever followed by a second tick. A zero step or a low enable never yields a tick. Only the bench scenarios can show the exact cycle on which each tick lands for a given scale/step pair. They also show the exact tick total over a full accumulator period, the one-edge restart after a configuration change, and the long wait at the maximum prescale.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned BAUD_SCALE_W = 12;
  localparam int unsigned BAUD_STEP_W  = 16;
  localparam int unsigned BAUD_ACC_W   = 17;
endpackage

// File: rtl/baud_cfg_guard.sv
module baud_cfg_guard #(
  parameter int unsigned SCALE_W = 12,
  parameter int unsigned STEP_W  = 16
) (
  input  logic               clk,
  input  logic               en,
  input  logic [SCALE_W-1:0] scale,
  input  logic [STEP_W-1:0]  step,
  output logic               clear
);
  logic [SCALE_W-1:0] scale_q;
  logic [STEP_W-1:0]  step_q;

  // Last-seen configuration, captured on every edge including reset.
  always_ff @(posedge clk) begin
    scale_q <= scale;
    step_q  <= step;
  end

  assign clear = !en || (scale != scale_q) || (step != step_q);
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned SCALE_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [SCALE_W-1:0] scale,
  output logic               pulse
);
  logic [SCALE_W-1:0] cnt;
  logic               at_top;

  assign at_top = (cnt == scale);
  assign pulse  = at_top && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear)   cnt <= '0;
    else if (at_top)    cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  // R3: whenever no clear is pending, the count is within the divide range
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    !clear |-> (cnt <= scale));
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int unsigned STEP_W = 16,
  parameter int unsigned ACC_W  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              pulse,
  input  logic [STEP_W-1:0] step,
  output logic              tick
);
  localparam int unsigned PAD_W = ACC_W + 1 - STEP_W;

  logic [ACC_W-1:0] phase;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, phase} + {{PAD_W{1'b0}}, step};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= pulse && sum[ACC_W];
      if (pulse) phase <= sum[ACC_W-1:0];
    end
  end

  // R4: a tick only ever follows a prescaler pulse
  a_r4_tick_after_pulse: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(pulse));
  // R2: step below half the modulus cannot overflow twice in a row
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R5: a zero increment never produces a carry
  a_r5_zero_step: assert property (@(posedge clk) disable iff (rst)
    ($past(step) == '0) |-> !tick);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned SCALE_W = BAUD_SCALE_W,
  parameter int unsigned STEP_W  = BAUD_STEP_W,
  parameter int unsigned ACC_W   = BAUD_ACC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [SCALE_W-1:0] scale,
  input  logic [STEP_W-1:0]  step,
  output logic               tick
);
  logic clear;
  logic pulse;

  baud_cfg_guard #(.SCALE_W(SCALE_W), .STEP_W(STEP_W)) u_guard (
    .clk(clk), .en(en), .scale(scale), .step(step), .clear(clear)
  );

  baud_prescaler #(.SCALE_W(SCALE_W)) u_pre (
    .clk(clk), .rst(rst), .clear(clear), .scale(scale), .pulse(pulse)
  );

  baud_phase_acc #(.STEP_W(STEP_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .clear(clear), .pulse(pulse), .step(step),
    .tick(tick)
  );

  // R7: a disabled edge leaves the strobe low
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick);
  // R8: an edge that sees a new step value leaves the strobe low
  a_r8_step_change_quiet: assert property (@(posedge clk) disable iff (rst)
    (step != $past(step)) |=> !tick);
endmodule

// File: tb/frac_baud_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic [11:0] scale;
  logic [15:0] step;
  logic        tick;

  always #2.5 clk = ~clk;

  frac_baud_gen u_dut (
    .clk(clk), .rst(rst), .en(en), .scale(scale), .step(step), .tick(tick)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  int    tick_count = 0;
  int    cyc = 0;
  bit    finished = 0;
  bit    exp_q[$];
  string tag_q[$];

  // Reference state for the expected-value model
  longint      k = 0;
  logic [11:0] pv_scale = '0;
  logic [15:0] pv_step  = '0;

  task automatic report_done();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: called at a negedge with inputs applied; predicts the next edge.
  task automatic edge_expect(input string tag);
    bit e;
    longint d, p, sv;
    e = 0;
    if (rst || !en || scale != pv_scale || step != pv_step) begin
      k = 0;
    end else begin
      k++;
      d = longint'(scale) + 1;
      sv = longint'(step);
      if (k % d == 0) begin
        p = k / d;
        e = ((p * sv) >> 17) != (((p - 1) * sv) >> 17);
      end
    end
    pv_scale = scale;
    pv_step  = step;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) edge_expect(tag);
  endtask

  // Monitor: compares just after each edge
  always @(posedge clk) begin
    bit    e;
    string t;
    #1;
    cyc++;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (tick !== e) begin
        n_fail++;
        $display("FAIL %s: tick=%0b expected=%0b at cycle %0d", t, tick, e, cyc);
      end
      if (tick === 1'b1) tick_count++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    report_done();
  end

  initial begin
    rst = 1; en = 1; scale = 12'd0; step = 16'h8000;
    @(negedge clk);
    run(4, "R1");                       // reset holds tick low
    rst = 0;
    run(40, "R3");                      // scale 0: pulse every edge, tick every 4
    scale = 12'd3; step = 16'h5555;
    run(300, "R4");
    step = 16'h0000;
    tick_count = 0;
    run(200, "R5");
    check("R5", tick_count, 0);
    scale = 12'd2; step = 16'h9000;
    run(50, "R7");
    en = 0;
    run(5, "R7");
    en = 1;
    run(60, "R7");
    step = 16'hF000;                    // mid-run change restarts the phase
    run(30, "R8");
    scale = 12'd0; step = 16'hFFFF;
    run(20, "R2");
    scale = 12'hFFF; step = 16'hFFFF;
    tick_count = 0;
    run(13000, "R9");
    check("R9", tick_count, 1);
    scale = 12'd0; step = 16'hABCD;
    tick_count = 0;
    run(131073, "R6");                  // one clear edge plus a full window
    check("R6", tick_count, 32'hABCD);
    report_done();
  end
endmodule